// File: doc/BRIEF.md
# SD Card SPI-Mode Command and Response Engine

This block issues one command to a memory card running in SPI mode and collects the card's answer. On a start pulse it captures a 6-bit command index, a 32-bit argument, a 7-bit CRC, a flag asking for four trailing response bytes, and a flag asking that the card stay selected afterwards. It then lowers chip select and sends a six-byte frame through a byte-level SPI shifter. It polls with all-ones fill bytes until a received byte has its top bit clear. That byte is the status (R1) response. When asked, the block then reads four more bytes into a 32-bit word. Last, it closes the transaction according to the keep-selected flag.

The shifter handshake works one byte at a time. The engine holds `xfer_req` high with a byte on `xfer_tx`. The shifter answers with a one-cycle `xfer_ack` and, in that same cycle, the byte it received on `xfer_rx`. A controller at a higher level sequences the commands. A data phase may follow a command that was issued with keep-selected set.

The state machine has six states:
- ST_IDLE: waiting for start.
- ST_SEND: sending the six frame bytes.
- ST_POLL: sending fill bytes and watching for the response.
- ST_TRAIL: reading the four trailing bytes.
- ST_TAIL: chip select is high and one extra fill byte is sent.
- ST_FIN: done pulse.

Its transitions are:
- IDLE to SEND on start.
- SEND to POLL after the sixth byte.
- POLL to TRAIL on a valid response when trailing bytes are requested.
- POLL to FIN on a valid response in keep mode with no trailing bytes.
- POLL to TAIL on a valid response in normal mode, or on timeout.
- TRAIL to FIN (keep mode) or to TAIL (normal mode) after the fourth trailing byte.
- TAIL to FIN.
- FIN to IDLE.

Top module: `sdc_cmd_engine`

## Requirements
- R1: The first frame byte is binary 01 in bits 7:6 with the command index in bits 5:0.
- R2: Frame bytes two to five carry the argument, most significant byte first.
- R3: The sixth frame byte is the 7-bit CRC in bits 7:1 with bit 0 forced to 1 (a CRC of 0x4A gives 0x95).
- R4: `cs_n` goes low before the first frame byte is requested. It stays low through the frame, the polling and the trailing bytes.
- R5: After the frame, every byte sent is 0xFF. The first received byte with bit 7 clear is returned on `r1` unchanged, with all its flag bits (bit 0 idle, bit 2 illegal command) intact.
- R6: If POLL_LIMIT (default 5000) poll bytes pass with no valid response, `timeout` is set and `r1` reads 0xFF. A valid response on the last allowed poll byte is accepted without timeout.
- R7: With `read_trail` set, the four bytes after the response are packed MSB first into `trail_word`. With it clear, no trailing bytes are read and `trail_word` is 0.
- R8: In normal mode `cs_n` rises after the response (and any trailing bytes), then exactly one more 0xFF byte is sent. In keep mode with a valid response, `cs_n` stays low and no extra byte is sent. On timeout the normal close-out applies even in keep mode.
- R9: `done` is high for exactly one cycle per command. `r1`, `trail_word` and `timeout` hold their values until the next accepted start.
- R10: A start pulse while a command is in progress is ignored. The frame in flight is unchanged and only one `done` occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_crc7 | input | 7 | CRC field of the last frame byte |
| read_trail | input | 1 | Read four trailing bytes after the response |
| keep_sel | input | 1 | Leave card selected after a valid response |
| cs_n | output | 1 | Card chip select, active low |
| xfer_req | output | 1 | Byte transfer request to the shifter |
| xfer_tx | output | 8 | Byte to transmit |
| xfer_ack | input | 1 | Byte transfer complete, one cycle |
| xfer_rx | input | 8 | Byte received, valid with xfer_ack |
| r1 | output | 8 | Status response byte |
| trail_word | output | 32 | Trailing response word |
| done | output | 1 | Command finished, one-cycle pulse |
| timeout | output | 1 | No response within the poll limit |

## Verification
The two events that can fall in the same cycle are the poll counter reaching its limit and the arrival of a valid response. The bench provokes this by placing the response on exactly the 5000th poll byte. It then expects a clean result: the response value on `r1`, `timeout` low, and a byte count that ends with one close-out byte. A separate run sends no response at all and expects a timeout after exactly 5000 polls. Keep mode is checked in a further run, where a valid response must leave the card selected with no extra byte sent.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_POLL,
        ST_TRAIL,
        ST_TAIL,
        ST_FIN
    } sdc_state_t;

    localparam logic [7:0] FILL_BYTE   = 8'hFF;
    localparam logic [1:0] START_BITS  = 2'b01;
    localparam int         FRAME_BYTES = 6;
    localparam int         TRAIL_BYTES = 4;
endpackage

// File: rtl/sdc_frame_mux.sv
module sdc_frame_mux
    import sdc_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [5:0]       cmd,
    input  logic [31:0]      arg,
    input  logic [6:0]       crc7,
    output logic [7:0]       byte_o
);
    always_comb begin
        byte_o = FILL_BYTE;
        if (idx == '0)
            byte_o = {START_BITS, cmd};
        else if (int'(idx) == FRAME_BYTES - 1)
            byte_o = {crc7, 1'b1};
        else begin
            for (int k = 1; k <= 4; k++)
                if (int'(idx) == k)
                    byte_o = arg[(4-k)*8 +: 8];
        end
    end

    always_comb begin
        if (idx == '0)
            assert_start_bits_R1: assert (byte_o[7:6] == START_BITS);
        if (int'(idx) == FRAME_BYTES - 1)
            assert_stop_bit_R3: assert (byte_o[0] == 1'b1);
    end
endmodule

// File: rtl/sdc_poll_ctr.sv
module sdc_poll_ctr #(
    parameter int LIMIT = 5000,
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (step && !last)
            cnt <= cnt + 1'b1;
    end

    assign last = (cnt == CW'(LIMIT - 1));

    assert_ctr_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        last && !clear |=> last || $past(step));
endmodule

// File: rtl/sdc_resp_capture.sv
module sdc_resp_capture #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load_r1,
    input  logic              shift_en,
    input  logic [7:0]        byte_in,
    output logic [7:0]        r1_q,
    output logic [WORD_W-1:0] word_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r1_q   <= 8'hFF;
            word_q <= '0;
        end else if (clear) begin
            r1_q   <= 8'hFF;
            word_q <= '0;
        end else begin
            if (load_r1)
                r1_q <= byte_in;
            if (shift_en)
                word_q <= {word_q[WORD_W-9:0], byte_in};
        end
    end

    assert_r1_msb_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_r1 && !clear |=> !r1_q[7]);
endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
    import sdc_pkg::*;
#(
    parameter int POLL_LIMIT = 5000,
    localparam int IDX_W = $clog2(FRAME_BYTES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [5:0]  cmd_idx,
    input  logic [31:0] cmd_arg,
    input  logic [6:0]  cmd_crc7,
    input  logic        read_trail,
    input  logic        keep_sel,
    output logic        cs_n,
    output logic        xfer_req,
    output logic [7:0]  xfer_tx,
    input  logic        xfer_ack,
    input  logic [7:0]  xfer_rx,
    output logic [7:0]  r1,
    output logic [31:0] trail_word,
    output logic        done,
    output logic        timeout
);
    sdc_state_t       state, state_nx;
    logic [IDX_W-1:0] idx;
    logic [5:0]       cmd_q;
    logic [31:0]      arg_q;
    logic [6:0]       crc_q;
    logic             trail_q, keep_q;
    logic             accept, poll_last, rx_valid;
    logic             load_r1, shift_en, ctr_step;
    logic [7:0]       frame_byte;

    assign accept   = (state == ST_IDLE) && start;
    assign rx_valid = xfer_ack && !xfer_rx[7];
    assign load_r1  = (state == ST_POLL) && rx_valid;
    assign shift_en = (state == ST_TRAIL) && xfer_ack;
    assign ctr_step = (state == ST_POLL) && xfer_ack;

    sdc_frame_mux #(.IDX_W(IDX_W)) u_frame (
        .idx(idx), .cmd(cmd_q), .arg(arg_q), .crc7(crc_q), .byte_o(frame_byte)
    );

    sdc_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk(clk), .rst_n(rst_n), .clear(accept), .step(ctr_step), .last(poll_last)
    );

    sdc_resp_capture #(.WORD_W(32)) u_cap (
        .clk(clk), .rst_n(rst_n), .clear(accept), .load_r1(load_r1),
        .shift_en(shift_en), .byte_in(xfer_rx), .r1_q(r1), .word_q(trail_word)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_SEND;
            ST_SEND:  if (xfer_ack && int'(idx) == FRAME_BYTES - 1) state_nx = ST_POLL;
            ST_POLL:
                if (rx_valid)
                    state_nx = trail_q ? ST_TRAIL : (keep_q ? ST_FIN : ST_TAIL);
                else if (xfer_ack && poll_last)
                    state_nx = ST_TAIL;
            ST_TRAIL: if (xfer_ack && int'(idx) == TRAIL_BYTES - 1)
                          state_nx = keep_q ? ST_FIN : ST_TAIL;
            ST_TAIL:  if (xfer_ack) state_nx = ST_FIN;
            ST_FIN:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register and sequencing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            cmd_q   <= '0;
            arg_q   <= '0;
            crc_q   <= '0;
            trail_q <= 1'b0;
            keep_q  <= 1'b0;
            cs_n    <= 1'b1;
            timeout <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                cmd_q   <= cmd_idx;
                arg_q   <= cmd_arg;
                crc_q   <= cmd_crc7;
                trail_q <= read_trail;
                keep_q  <= keep_sel;
                idx     <= '0;
                cs_n    <= 1'b0;
                timeout <= 1'b0;
            end
            if ((state == ST_SEND || state == ST_TRAIL) && xfer_ack)
                idx <= (state_nx == state) ? idx + 1'b1 : '0;
            if (state == ST_POLL && rx_valid)
                idx <= '0;
            if (state_nx == ST_TAIL && state != ST_TAIL)
                cs_n <= 1'b1;
            if (state == ST_POLL && !rx_valid && xfer_ack && poll_last)
                timeout <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        xfer_req = 1'b0;
        xfer_tx  = FILL_BYTE;
        done     = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_SEND:  begin xfer_req = 1'b1; xfer_tx = frame_byte; end
            ST_POLL,
            ST_TRAIL,
            ST_TAIL:  xfer_req = 1'b1;
            ST_FIN:   done = 1'b1;
            default:  ;
        endcase
    end

    assert_cs_low_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && (state == ST_SEND || state == ST_POLL || state == ST_TRAIL) |-> !cs_n);
    assert_fill_after_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && state != ST_SEND |-> xfer_tx == FILL_BYTE);
    assert_timeout_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done && timeout |-> cs_n);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE && !start |=> $stable(r1) && $stable(trail_word) && $stable(timeout));
    assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_IDLE && state != ST_FIN |=> $stable(cmd_q) && $stable(arg_q));
endmodule

// File: tb/sim_sdc_cmd_engine.sv
module sim_sdc_cmd_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  cmd_idx = '0;
    logic [31:0] cmd_arg = '0;
    logic [6:0]  cmd_crc7 = '0;
    logic        read_trail = 1'b0, keep_sel = 1'b0;
    logic        cs_n, xfer_req, xfer_ack = 1'b0;
    logic [7:0]  xfer_tx, xfer_rx = 8'hFF;
    logic [7:0]  r1;
    logic [31:0] trail_word;
    logic        done, timeout;

    int checks = 0, fails = 0, cycles = 0;
    // response script and transaction log
    int          rpos;
    logic [7:0]  r1val;
    logic [31:0] tword;
    logic [7:0]  txlog [0:5];
    int          nbytes, bad_fill, cs_high_open;
    logic        first_cs, last_cs;
    logic [7:0]  last_tx;
    int          done_seen;

    always #10 clk = ~clk;

    sdc_cmd_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
        .cmd_crc7(cmd_crc7), .read_trail(read_trail), .keep_sel(keep_sel), .cs_n(cs_n),
        .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
        .r1(r1), .trail_word(trail_word), .done(done), .timeout(timeout)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    function automatic logic [7:0] resp_byte(input int n);
        int p = n - 6;
        if (p < 0 || rpos < 0 || p < rpos) return 8'hFF;
        if (p == rpos) return r1val;
        if (p <= rpos + 4) return tword[(4-(p-rpos))*8 +: 8];
        return 8'hFF;
    endfunction

    task automatic tick();
        @(negedge clk);
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            finish_run();
        end
    endtask

    // runs one command, acting as the byte shifter; interfere>=0 pulses start at that byte
    task automatic run_cmd(input logic [5:0] c, input logic [31:0] a, input logic [6:0] crc,
                           input logic tr, input logic kp, input int interfere);
        int  n = 0;
        logic fin = 1'b0;
        bad_fill = 0; cs_high_open = 0; done_seen = 0;
        tick();
        cmd_idx = c; cmd_arg = a; cmd_crc7 = crc; read_trail = tr; keep_sel = kp; start = 1'b1;
        tick();
        start = 1'b0;
        first_cs = cs_n;
        while (!fin) begin
            if (done) begin
                done_seen++;
                fin = 1'b1;
            end
            if (xfer_ack) begin
                xfer_ack = 1'b0;
                xfer_rx = 8'hFF;
            end else if (xfer_req) begin
                if (n < 6) txlog[n] = xfer_tx;
                else if (xfer_tx !== 8'hFF) bad_fill++;
                if (n == 0) first_cs = cs_n;
                last_cs = cs_n; last_tx = xfer_tx;
                xfer_rx = resp_byte(n);
                xfer_ack = 1'b1;
                n++;
                if (n == interfere) begin
                    start = 1'b1; cmd_idx = 6'h3F; cmd_arg = 32'hDEAD_BEEF;
                end
            end
            if (!fin) tick();
            if (n == interfere + 2) start = 1'b0;
        end
        start = 1'b0;
        xfer_ack = 1'b0;
        nbytes = n;
        tick();
        chk("R9 done width", {31'b0, done}, 32'h0);
    endtask

    task automatic check_frame(input logic [5:0] c, input logic [31:0] a, input logic [6:0] crc);
        chk("R1 first byte", {24'b0, txlog[0]}, {24'b0, 2'b01, c});
        chk("R2 argument bytes", {txlog[1], txlog[2], txlog[3], txlog[4]}, a);
        chk("R3 crc byte", {24'b0, txlog[5]}, {24'b0, crc, 1'b1});
        chk("R4 cs low at first byte", {31'b0, first_cs}, 32'h0);
        chk("R5 fill bytes", bad_fill, 0);
    endtask

    task automatic t_reset();
        chk("R9 reset done", {31'b0, done}, 0);
        chk("R4 reset cs_n", {31'b0, cs_n}, 1);
        chk("R9 reset req", {31'b0, xfer_req}, 0);
        chk("R6 reset timeout", {31'b0, timeout}, 0);
    endtask

    task automatic t_basic();
        rpos = 2; r1val = 8'h01; tword = 32'h0;
        run_cmd(6'd0, 32'h0, 7'h4A, 1'b0, 1'b0, -1);
        check_frame(6'd0, 32'h0, 7'h4A);
        chk("R3 crc 0x95", {24'b0, txlog[5]}, 32'h95);
        chk("R5 r1 value", {24'b0, r1}, 32'h01);
        chk("R8 byte count", nbytes, 6 + 3 + 1);
        chk("R8 tail cs high", {31'b0, last_cs}, 1);
        chk("R8 cs_n after", {31'b0, cs_n}, 1);
        chk("R7 no trail", trail_word, 0);
        chk("R6 no timeout", {31'b0, timeout}, 0);
        chk("R9 single done", done_seen, 1);
    endtask

    task automatic t_trail();
        rpos = 0; r1val = 8'h00; tword = 32'hC0FF_8000;
        run_cmd(6'd58, 32'h1234_5678, 7'h7F, 1'b1, 1'b0, -1);
        check_frame(6'd58, 32'h1234_5678, 7'h7F);
        chk("R7 trail word", trail_word, 32'hC0FF_8000);
        chk("R8 byte count trail", nbytes, 6 + 1 + 4 + 1);
        chk("R8 cs_n after trail", {31'b0, cs_n}, 1);
    endtask

    task automatic t_keep();
        rpos = 1; r1val = 8'h05; tword = 32'h0;
        run_cmd(6'd17, 32'h0000_0200, 7'h00, 1'b0, 1'b1, -1);
        check_frame(6'd17, 32'h0000_0200, 7'h00);
        chk("R5 r1 flags kept", {24'b0, r1}, 32'h05);
        chk("R8 keep no extra byte", nbytes, 6 + 2);
        chk("R8 keep cs low", {31'b0, cs_n}, 0);
        chk("R8 keep last cs", {31'b0, last_cs}, 0);
        for (int i = 0; i < 5; i++) tick();
        chk("R9 r1 held", {24'b0, r1}, 32'h05);
        chk("R8 keep cs still low", {31'b0, cs_n}, 0);
    endtask

    task automatic t_keep_trail();
        rpos = 0; r1val = 8'h00; tword = 32'h0000_01AA;
        run_cmd(6'd8, 32'h0000_01AA, 7'h43, 1'b1, 1'b1, -1);
        chk("R7 keep trail word", trail_word, 32'h0000_01AA);
        chk("R8 keep trail count", nbytes, 6 + 1 + 4);
        chk("R8 keep trail cs", {31'b0, cs_n}, 0);
    endtask

    task automatic t_timeout();
        rpos = -1; r1val = 8'h00; tword = 32'h0;
        run_cmd(6'd41, 32'h4000_0000, 7'h00, 1'b1, 1'b1, -1);
        chk("R6 timeout flag", {31'b0, timeout}, 1);
        chk("R6 timeout r1", {24'b0, r1}, 32'hFF);
        chk("R6 poll count", nbytes, 6 + 5000 + 1);
        chk("R8 timeout closes", {31'b0, cs_n}, 1);
        chk("R8 timeout tail cs", {31'b0, last_cs}, 1);
        for (int i = 0; i < 4; i++) tick();
        chk("R9 timeout held", {31'b0, timeout}, 1);
    endtask

    task automatic t_last_poll();
        rpos = 4999; r1val = 8'h00; tword = 32'h0;
        run_cmd(6'd55, 32'h0, 7'h00, 1'b0, 1'b0, -1);
        chk("R6 late response no timeout", {31'b0, timeout}, 0);
        chk("R6 late response r1", {24'b0, r1}, 32'h00);
        chk("R6 late response count", nbytes, 6 + 5000 + 1);
    endtask

    task automatic t_busy_start();
        rpos = 1; r1val = 8'h00; tword = 32'h0;
        run_cmd(6'd16, 32'h0000_0200, 7'h0A, 1'b0, 1'b0, 3);
        check_frame(6'd16, 32'h0000_0200, 7'h0A);
        chk("R10 single done", done_seen, 1);
        chk("R10 count unchanged", nbytes, 6 + 2 + 1);
        for (int i = 0; i < 4; i++) tick();
        chk("R10 stays idle", {31'b0, xfer_req}, 0);
    endtask

    initial begin
        tick(); tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_basic();
        t_trail();
        t_keep();
        t_keep_trail();
        t_timeout();
        t_last_poll();
        t_busy_start();
        finish_run();
    end
endmodule